// File: doc/BRIEF.md
# Evolvable LUT Cell Array

A combinational fabric of configurable logic cells, five columns deep and eight rows tall, that a search engine elsewhere on the chip reprograms to try candidate circuits. Every cell owns a 3-input lookup table. Each table input is chosen by its own 16-way multiplexer, which can pick any output of the two columns just before the cell. An 8-bit vector enters at the left edge, and the eight outputs of the last column form the array's result.

Each cell keeps its 20-bit configuration in a register. A plain write port loads these registers: a cell index, a write strobe and a data word. The array itself has no clock between input and output. The result follows the input vector combinationally, so the vector path has no valid/ready pair and no back-pressure. A caller applies a vector and samples the result once the logic has settled. Configuration writes are the only clocked path.

Top module: `evo_lut_array`

## Requirements
- R1: An active-low reset clears every configuration register to zero. With all tables zero, `arr_out` is 0 for every input vector.
- R2: When `cfg_we` is high and `cfg_idx` is below 40, `cfg_data` is stored for cell `cfg_idx` at the clock edge and affects `arr_out` after that edge. Cells are indexed as column×8 + row.
- R3: A write whose `cfg_idx` is 40 or more is ignored. No cell changes, so `arr_out` stays as the existing configuration gives it.
- R4: With `cfg_we` low, the configuration does not change.
- R5: The configuration word has these fields:
  - bits [7:0] hold the table;
  - bits [11:8] select table input 0;
  - bits [15:12] select table input 1;
  - bits [19:16] select table input 2.
  The cell outputs table bit {in2,in1,in0}.
- R6: Select value k in 0..7 picks row k of the nearer preceding column. Select value k in 8..15 picks row k−8 of the column two back.
- R7: In column 0, the nearer sources are the array inputs and the farther sources are the bitwise-inverted array inputs.
- R8: In column 1, the farther sources are the true array inputs.
- R9: `arr_out[r]` is the output of the column-4 cell in row r.
- R10: `arr_out` follows a change of `arr_in` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset, clears all configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Target cell index, column×8 + row |
| cfg_data | input | 20 | Configuration word for the target cell |
| arr_in | input | 8 | Input vector to the fabric |
| arr_out | output | 8 | Outputs of the last column |

## Verification
The bench builds the array with its default size: 8 rows by 5 columns. That gives 40 cells behind a 6-bit index, so the 24 unused index values 40..63 can be driven, and the ignored-write rule gets exercised against a live configuration. Five columns give every column-specific routing case: inverted sources in column 0, true inputs as the far source in column 1, and column-to-column links two back from column 2 onward. With 16 sources per multiplexer, random select fields reach both halves of each choice.

// File: rtl/evo_pkg.sv
package evo_pkg;
  // number of inputs of every lookup table
  localparam int unsigned LUT_IN   = 3;
  // table bits, one per input combination
  localparam int unsigned LUT_BITS = 1 << LUT_IN;
endpackage

// File: rtl/evo_cell.sv
module evo_cell
  import evo_pkg::*;
#(
  parameter int unsigned NCAND = 16,
  localparam int unsigned SEL_W = $clog2(NCAND),
  localparam int unsigned CFG_W = LUT_BITS + LUT_IN * SEL_W
) (
  input  logic [NCAND-1:0] cand,
  input  logic [CFG_W-1:0] cfg,
  output logic             y
);
  logic [LUT_IN-1:0]   addr;
  logic [LUT_BITS-1:0] table_bits;

  assign table_bits = cfg[LUT_BITS-1:0];

  for (genvar j = 0; j < LUT_IN; j++) begin : g_mux
    logic [SEL_W-1:0] sel;
    assign sel     = cfg[LUT_BITS + j*SEL_W +: SEL_W];
    assign addr[j] = cand[sel];
  end

  assign y = table_bits[addr];
endmodule

// File: rtl/evo_column.sv
module evo_column
  import evo_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  localparam int unsigned NCAND = 2 * ROWS,
  localparam int unsigned SEL_W = $clog2(NCAND),
  localparam int unsigned CFG_W = LUT_BITS + LUT_IN * SEL_W
) (
  input  logic [ROWS-1:0]       near_src,
  input  logic [ROWS-1:0]       far_src,
  input  logic [ROWS*CFG_W-1:0] cfg_col,
  output logic [ROWS-1:0]       col_y
);
  logic [NCAND-1:0] cand;
  // sources 0..ROWS-1 from the nearer column, the rest from the farther one
  assign cand = {far_src, near_src};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    evo_cell #(.NCAND(NCAND)) u_cell (
      .cand (cand),
      .cfg  (cfg_col[r*CFG_W +: CFG_W]),
      .y    (col_y[r])
    );
  end
endmodule

// File: rtl/evo_cfg_bank.sv
module evo_cfg_bank #(
  parameter int unsigned CELLS = 40,
  parameter int unsigned CFG_W = 20,
  localparam int unsigned IDX_W = $clog2(CELLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [CFG_W-1:0]       cfg_data,
  output logic [CELLS*CFG_W-1:0] cfg_flat
);
  logic [CFG_W-1:0] mem [CELLS];
  logic             in_range;

  assign in_range = ({1'b0, cfg_idx} < (IDX_W+1)'(CELLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= '0;
    end else if (cfg_we && in_range) begin
      mem[cfg_idx] <= cfg_data;
    end
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_flat
    assign cfg_flat[i*CFG_W +: CFG_W] = mem[i];
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_range) |=> (cfg_flat[$past(cfg_idx)*CFG_W +: CFG_W] == $past(cfg_data)));

  // R3
  cfg_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !in_range) |=> $stable(cfg_flat));

  // R4
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_flat));
endmodule

// File: rtl/evo_lut_array.sv
module evo_lut_array
  import evo_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 5,
  localparam int unsigned CELLS = ROWS * COLS,
  localparam int unsigned IDX_W = $clog2(CELLS),
  localparam int unsigned SEL_W = $clog2(2 * ROWS),
  localparam int unsigned CFG_W = LUT_BITS + LUT_IN * SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [ROWS-1:0]  arr_in,
  output logic [ROWS-1:0]  arr_out
);
  logic [CELLS*CFG_W-1:0] cfg_flat;

  evo_cfg_bank #(.CELLS(CELLS), .CFG_W(CFG_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data),
    .cfg_flat (cfg_flat)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] near_src;
    logic [ROWS-1:0] far_src;
    logic [ROWS-1:0] y;

    if (c == 0) begin : g_first
      assign near_src = arr_in;
      assign far_src  = ~arr_in;
    end else if (c == 1) begin : g_second
      assign near_src = g_col[0].y;
      assign far_src  = arr_in;
    end else begin : g_rest
      assign near_src = g_col[c-1].y;
      assign far_src  = g_col[c-2].y;
    end

    evo_column #(.ROWS(ROWS)) u_column (
      .near_src (near_src),
      .far_src  (far_src),
      .cfg_col  (cfg_flat[c*ROWS*CFG_W +: ROWS*CFG_W]),
      .col_y    (y)
    );
  end

  assign arr_out = g_col[COLS-1].y;

  // R1
  reset_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (arr_out == '0));
endmodule

// File: tb/sim_evo_lut_array.sv
module sim_evo_lut_array;
  localparam int NR = 8;
  localparam int NC = 5;
  localparam int NCELL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [19:0] cfg_data = '0;
  logic [7:0]  arr_in = '0;
  logic [7:0]  arr_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [19:0] shadow [NCELL];

  always #4 clk = ~clk;

  evo_lut_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .arr_in(arr_in), .arr_out(arr_out)
  );

  function automatic logic [7:0] ref_out(input logic [7:0] x);
    logic [7:0] col [NC];
    for (int c = 0; c < NC; c++) begin
      logic [7:0] nr, fr;
      logic [15:0] cand;
      nr = (c == 0) ? x : col[c-1];
      fr = (c == 0) ? ~x : ((c == 1) ? x : col[c-2]);
      cand = {fr, nr};
      for (int r = 0; r < NR; r++) begin
        logic [19:0] w;
        logic [2:0] a;
        w = shadow[c*NR + r];
        a = {cand[w[19:16]], cand[w[15:12]], cand[w[11:8]]};
        col[c][r] = w[a];
      end
    end
    return col[NC-1];
  endfunction

  function automatic logic [19:0] mk(input logic [7:0] t, input int s0, input int s1, input int s2);
    return {4'(s2), 4'(s1), 4'(s0), t};
  endfunction

  task automatic wr(input int idx, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NCELL) shadow[idx] = d;
  endtask

  task automatic check(input string tag, input logic [7:0] x, input logic [7:0] exp);
    arr_in = x;
    #1;
    n_vec++;
    if (arr_out !== exp) begin
      n_bad++;
      $display("FAIL %s in=%h actual=%h expected=%h", tag, x, arr_out, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NCELL; i++) shadow[i] = '0;
  endtask

  // write the same pattern into all rows of one column; select offset is added per row
  task automatic fill_col(input int c, input logic [7:0] t, input int base0, input int base1, input int base2);
    for (int r = 0; r < NR; r++) wr(c*NR + r, mk(t, base0 + r, base1 + r, base2 + r));
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCELL; i++) shadow[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state gives zero output
    check("R1", 8'h00, 8'h00);
    check("R1", 8'hFF, 8'h00);
    check("R1", 8'h5A, 8'h00);

    // R7 R9: pass-through chain along near row, column 0 takes true inputs
    for (int c = 0; c < NC; c++) fill_col(c, 8'hAA, 0, 0, 0);
    check("R7", 8'h3C, 8'h3C);
    check("R9", 8'hA1, 8'hA1);
    // R10: output follows the input with no clock edge in between
    arr_in = 8'h0F; #1; arr_in = 8'hF0; #1;
    n_vec++;
    if (arr_out !== 8'hF0) begin
      n_bad++; $display("FAIL R10 actual=%h expected=%h", arr_out, 8'hF0);
    end

    // R7: column 0 far sources are inverted inputs
    fill_col(0, 8'hAA, 8, 0, 0);
    check("R7", 8'h3C, 8'hC3);
    // R8: column 1 far sources are the true inputs
    fill_col(1, 8'hAA, 8, 0, 0);
    check("R8", 8'h96, 8'h96);

    // R6: column 1 inverts column 0, column 2 reaches two back
    fill_col(0, 8'hAA, 0, 0, 0);
    fill_col(1, 8'h55, 0, 0, 0);
    fill_col(2, 8'hAA, 8, 0, 0);
    check("R6", 8'h71, 8'h71);
    fill_col(2, 8'hAA, 0, 0, 0);
    check("R6", 8'h71, 8'h8E);

    // R5: table address bit 1 from mux1, bit 2 from mux2
    fill_col(2, 8'hCC, 0, 8, 0);
    check("R5", 8'h4D, 8'h4D);
    fill_col(2, 8'hF0, 0, 0, 0);
    check("R5", 8'h4D, 8'hB2);

    // R3: out-of-range writes leave the configuration intact
    for (int i = NCELL; i < 64; i++) wr(i, 20'hFFFFF);
    check("R3", 8'h4D, 8'hB2);
    check("R3", 8'h00, 8'hFF);

    // R4: idle cycles do not disturb anything
    cfg_data = 20'h12345; cfg_idx = 6'd33;
    repeat (5) @(negedge clk);
    check("R4", 8'h00, 8'hFF);

    // R2: random configurations, all writes checked through the output
    for (int round = 0; round < 30; round++) begin
      for (int k = 0; k < 50; k++) begin
        int idx;
        idx = int'($urandom_range(63, 0));
        wr(idx, 20'($urandom()));
      end
      for (int v = 0; v < 64; v++) begin
        logic [7:0] x;
        x = 8'($urandom());
        check("R2", x, ref_out(x));
      end
    end
    // R2: single write seen right after its edge
    wr(37, mk(8'hFF, 0, 0, 0));
    check("R2", 8'h11, ref_out(8'h11));

    // R1: reset in mid run clears everything
    do_reset();
    check("R1", 8'hC7, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule